// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block gathers interrupt events from on-chip sources and stores each one as a 16-byte record in a circular buffer in system memory, where a host drains them. Each event brings a source identifier, a 28-bit payload, a ring number, a virtual-memory context number and an address-space number. The block keeps byte-granular producer and consumer pointers and writes every record as four 32-bit word writes through a single-word memory write port with a valid/ready handshake. When enabled, it then writes the producer pointer to a second programmed address, so the host can poll memory instead of reading a register.

The host drives the block through a small register file. The registers hold control bits, the ring base, the pointer-copy address and both pointers. The interrupt output stays high while the ring has unread records. A ring that fills either holds new records back or overwrites the oldest ones and sets an overflow flag inside the producer-pointer value. A short input queue absorbs events while the ring is disabled or the memory port stalls. Events that find that queue full are discarded and counted.

Register map (3-bit address): 0 control, 1 ring base (address bits 39:8), 2 pointer-copy address bits 31:0, 3 pointer-copy address bits 39:32 in [7:0], 4 consumer pointer, 5 producer pointer, 6 discard count (read only). Control bits: [0] ring enable, [1] interrupt enable, [2] overflow mode, [3] overflow clear, [4] pointer copy enable, [5] rearm on consumer write, [12:8] log2 of the ring size in 32-bit words (valid 2 to 16).

Top module: `intr_ring_writer`

## Requirements
- R1: After reset, irq is 0, mem_wr_valid is 0, the producer pointer and the discard count read 0.
- R2: A record is written as four word writes to ring base + producer byte pointer + 0, 4, 8, 12. Word 0 holds the source in [7:0] with 0 above it. Word 1 holds the payload in [27:0] with 0 above it. Word 2 holds the ring number in [7:0], the context number in [15:8] and the address space in [31:16]. Word 3 is 0.
- R3: The producer pointer advances by 16 bytes per record and wraps at 4 << size bytes.
- R4: With pointer copy enabled, one further write follows each record. It goes to the 40-bit copy address and carries the producer-pointer register value after the advance. With copy disabled, no such write occurs.
- R5: With overflow mode on, a record whose advance would make the producer pointer equal the consumer pointer is still written, and bit 0 of the producer-pointer value is set.
- R6: With overflow mode off, such a record is held back. It is written once a consumer-pointer write makes room.
- R7: While the overflow-clear control bit is 1, the overflow flag reads 0.
- R8: irq is 1 exactly when ring enable and interrupt enable are set and the two pointers differ, except as R9 states.
- R9: With rearm set, a consumer-pointer write forces irq low for the next cycle, after which it follows R8 again. With rearm clear, no such gap occurs.
- R10: While the ring is disabled, events wait in a queue of FIFO_DEPTH entries. An event that arrives while the queue is full is discarded and raises the discard count by one. Queued events are written in arrival order once the ring is enabled.
- R11: While mem_wr_ready is 0, mem_wr_valid, mem_wr_addr and mem_wr_data hold steady.
- R12: The pointer registers load and return byte pointers in bits [17:4]; lower written bits are ignored. A producer-pointer write clears the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| ev_valid | input | 1 | Event present this cycle |
| ev_source | input | 8 | Event source identifier |
| ev_payload | input | 28 | Event payload |
| ev_ring | input | 8 | Event ring number |
| ev_vmid | input | 8 | Event virtual-memory context |
| ev_pasid | input | 16 | Event address-space number |
| mem_wr_valid | output | 1 | Memory word write request |
| mem_wr_ready | input | 1 | Memory accepts the write this cycle |
| mem_wr_addr | output | 40 | Byte address of the word |
| mem_wr_data | output | 32 | Word data |
| irq | output | 1 | Interrupt to the host |

## Verification
Single records are sent into a fresh ring first. A record under alternating memory stalls shows whether beats hold and whether the pointer copy is suppressed. A run of records that crosses the ring end separates correct masking from a pointer that runs past the ring. Records sent into a full ring are tried in both overflow modes, which tells overwrite-and-flag apart from hold-back. A burst into a disabled ring probes queue depth, discard counting and arrival order. Consumer-pointer writes with and without rearm tell the one-cycle interrupt gap apart from a plain level.

// File: rtl/irw_pkg.sv
package irw_pkg;
  localparam int ADDR_W = 40;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_BASE  = 3'd1;
  localparam logic [2:0] RA_WBLO  = 3'd2;
  localparam logic [2:0] RA_WBHI  = 3'd3;
  localparam logic [2:0] RA_RPTR  = 3'd4;
  localparam logic [2:0] RA_WPTR  = 3'd5;
  localparam logic [2:0] RA_DROPS = 3'd6;

  typedef struct packed {
    logic [15:0] pasid;
    logic [7:0]  vmid;
    logic [7:0]  ring_id;
    logic [27:0] payload;
    logic [7:0]  source;
  } irw_event_t;

  typedef struct packed {
    logic [4:0] size_log2;
    logic       rearm;
    logic       wb_en;
    logic       ovf_clr;
    logic       ovf_en;
    logic       intr_en;
    logic       ring_en;
  } irw_ctrl_t;
endpackage

// File: rtl/irw_event_fifo.sv
module irw_event_fifo
  import irw_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  irw_event_t        push_data,
  input  logic              pop,
  output logic              head_valid,
  output irw_event_t        head_data,
  output logic              full,
  output logic [DROP_W-1:0] drops
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  irw_event_t        store_q [DEPTH];
  logic [AW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DROP_W-1:0] drop_q, drop_d;
  logic              do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full       = (cnt_q == CW'(DEPTH));
  assign head_valid = (cnt_q != '0);
  assign head_data  = store_q[rd_q];
  assign drops      = drop_q;
  assign do_push    = push_valid & ~full;
  assign do_pop     = pop & head_valid;

  always_comb begin
    wr_d   = do_push ? bump(wr_q) : wr_q;
    rd_d   = do_pop ? bump(rd_q) : rd_q;
    cnt_d  = cnt_q;
    drop_d = drop_q;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    if (!do_push && do_pop) cnt_d = cnt_q - 1'b1;
    if (push_valid && full && (drop_q != '1)) drop_d = drop_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      drop_q <= '0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      cnt_q  <= cnt_d;
      drop_q <= drop_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store_q[wr_q] <= push_data;
  end
endmodule

// File: rtl/irw_ctrl_regs.sv
module irw_ctrl_regs
  import irw_pkg::*;
#(
  parameter int IDX_W  = 14,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              commit,
  input  logic              commit_ovf,
  input  logic [DROP_W-1:0] drops,
  output irw_ctrl_t         ctrl,
  output logic [31:0]       ring_base,
  output logic [ADDR_W-1:0] copy_addr,
  output logic [IDX_W-1:0]  rptr_idx,
  output logic [IDX_W-1:0]  wptr_idx,
  output logic [IDX_W-1:0]  mask_idx,
  output logic              ovf,
  output logic [31:0]       wptr_word,
  output logic              irq
);
  localparam int PTR_W = IDX_W + 4;

  irw_ctrl_t        ctrl_q, ctrl_d;
  logic [31:0]      base_q, base_d, wblo_q, wblo_d;
  logic [7:0]       wbhi_q, wbhi_d;
  logic [IDX_W-1:0] rptr_q, rptr_d, wptr_q, wptr_d;
  logic             ovf_q, ovf_d, gap_q, gap_d;
  logic             wr_rptr, wr_wptr;

  assign wr_rptr = reg_wr && (reg_addr == RA_RPTR);
  assign wr_wptr = reg_wr && (reg_addr == RA_WPTR);

  always_comb begin
    if (ctrl_q.size_log2 <= 5'd2) mask_idx = '0;
    else mask_idx = (IDX_W'(1) << (ctrl_q.size_log2 - 5'd2)) - IDX_W'(1);
  end

  always_comb begin
    ctrl_d = ctrl_q;
    base_d = base_q;
    wblo_d = wblo_q;
    wbhi_d = wbhi_q;
    rptr_d = rptr_q;
    wptr_d = wptr_q;
    ovf_d  = ovf_q;
    if (commit) begin
      wptr_d = (wptr_q + 1'b1) & mask_idx;
      ovf_d  = ovf_q | commit_ovf;
    end
    if (reg_wr) begin
      case (reg_addr)
        RA_CTRL: ctrl_d = irw_ctrl_t'({reg_wdata[12:8], reg_wdata[5:0]});
        RA_BASE: base_d = reg_wdata;
        RA_WBLO: wblo_d = reg_wdata;
        RA_WBHI: wbhi_d = reg_wdata[7:0];
        RA_RPTR: rptr_d = reg_wdata[PTR_W-1:4];
        RA_WPTR: begin
          wptr_d = reg_wdata[PTR_W-1:4];
          ovf_d  = 1'b0;
        end
        default: ;
      endcase
    end
    if (ctrl_q.ovf_clr) ovf_d = 1'b0;
    gap_d = wr_rptr & ctrl_q.rearm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      base_q <= '0;
      wblo_q <= '0;
      wbhi_q <= '0;
      rptr_q <= '0;
      wptr_q <= '0;
      ovf_q  <= 1'b0;
      gap_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      base_q <= base_d;
      wblo_q <= wblo_d;
      wbhi_q <= wbhi_d;
      rptr_q <= rptr_d;
      wptr_q <= wptr_d;
      ovf_q  <= ovf_d;
      gap_q  <= gap_d;
    end
  end

  assign ctrl      = ctrl_q;
  assign ring_base = base_q;
  assign copy_addr = {wbhi_q, wblo_q};
  assign rptr_idx  = rptr_q;
  assign wptr_idx  = wptr_q;
  assign ovf       = ovf_q;
  assign wptr_word = 32'({wptr_q, 3'b000, ovf_q});
  assign irq       = ctrl_q.ring_en & ctrl_q.intr_en & (rptr_q != wptr_q) & ~gap_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[12:8] = ctrl_q.size_log2;
        reg_rdata[5:0]  = {ctrl_q.rearm, ctrl_q.wb_en, ctrl_q.ovf_clr,
                           ctrl_q.ovf_en, ctrl_q.intr_en, ctrl_q.ring_en};
      end
      RA_BASE:  reg_rdata = base_q;
      RA_WBLO:  reg_rdata = wblo_q;
      RA_WBHI:  reg_rdata = 32'(wbhi_q);
      RA_RPTR:  reg_rdata = 32'({rptr_q, 4'b0000});
      RA_WPTR:  reg_rdata = wptr_word;
      RA_DROPS: reg_rdata = 32'(drops);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irw_vec_engine.sv
module irw_vec_engine
  import irw_pkg::*;
#(
  parameter int IDX_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_valid,
  input  irw_event_t        head_data,
  input  logic              ring_en,
  input  logic              ovf_en,
  input  logic              wb_en,
  input  logic [31:0]       ring_base,
  input  logic [ADDR_W-1:0] copy_addr,
  input  logic [IDX_W-1:0]  wptr_idx,
  input  logic [IDX_W-1:0]  rptr_idx,
  input  logic [IDX_W-1:0]  mask_idx,
  input  logic [31:0]       wptr_word,
  input  logic              mem_ready,
  output logic              pop,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  output logic              commit,
  output logic              commit_ovf
);
  typedef enum logic [1:0] {ST_IDLE, ST_VEC, ST_COPY} st_t;

  st_t              st_q, st_d;
  logic [1:0]       beat_q, beat_d;
  irw_event_t       cur_q, cur_d;
  logic [IDX_W-1:0] next_idx;
  logic             ring_full;

  assign next_idx  = (wptr_idx + 1'b1) & mask_idx;
  assign ring_full = (next_idx == rptr_idx);

  always_comb begin
    st_d       = st_q;
    beat_d     = beat_q;
    cur_d      = cur_q;
    pop        = 1'b0;
    commit     = 1'b0;
    commit_ovf = 1'b0;
    mem_valid  = 1'b0;
    mem_addr   = '0;
    mem_data   = '0;
    case (st_q)
      ST_IDLE: begin
        if (head_valid && ring_en && (!ring_full || ovf_en)) begin
          pop    = 1'b1;
          cur_d  = head_data;
          beat_d = 2'd0;
          st_d   = ST_VEC;
        end
      end
      ST_VEC: begin
        mem_valid = 1'b1;
        mem_addr  = {ring_base, 8'h00} + ADDR_W'({wptr_idx, 4'b0000})
                    + ADDR_W'({beat_q, 2'b00});
        case (beat_q)
          2'd0:    mem_data = {24'h0, cur_q.source};
          2'd1:    mem_data = {4'h0, cur_q.payload};
          2'd2:    mem_data = {cur_q.pasid, cur_q.vmid, cur_q.ring_id};
          default: mem_data = '0;
        endcase
        if (mem_ready) begin
          if (beat_q == 2'd3) begin
            commit     = 1'b1;
            commit_ovf = ovf_en & ring_full;
            st_d       = wb_en ? ST_COPY : ST_IDLE;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      ST_COPY: begin
        mem_valid = 1'b1;
        mem_addr  = copy_addr;
        mem_data  = wptr_word;
        if (mem_ready) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      cur_q  <= '0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
      cur_q  <= cur_d;
    end
  end
endmodule

// File: rtl/intr_ring_writer.sv
module intr_ring_writer
  import irw_pkg::*;
#(
  parameter int IDX_W      = 14,
  parameter int FIFO_DEPTH = 4,
  parameter int DROP_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ev_valid,
  input  logic [7:0]  ev_source,
  input  logic [27:0] ev_payload,
  input  logic [7:0]  ev_ring,
  input  logic [7:0]  ev_vmid,
  input  logic [15:0] ev_pasid,
  output logic        mem_wr_valid,
  input  logic        mem_wr_ready,
  output logic [39:0] mem_wr_addr,
  output logic [31:0] mem_wr_data,
  output logic        irq
);
  logic rst_meta_q, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  irw_event_t        ev_in, head_data;
  irw_ctrl_t         ctrl;
  logic              head_valid, fifo_full, pop, commit, commit_ovf, ovf;
  logic [DROP_W-1:0] drops;
  logic [31:0]       ring_base, wptr_word;
  logic [ADDR_W-1:0] copy_addr;
  logic [IDX_W-1:0]  rptr_idx, wptr_idx, mask_idx;

  assign ev_in = '{pasid: ev_pasid, vmid: ev_vmid, ring_id: ev_ring,
                   payload: ev_payload, source: ev_source};

  irw_event_fifo #(.DEPTH(FIFO_DEPTH), .DROP_W(DROP_W)) u_fifo (
    .clk(clk), .rst_n(rst_core_n),
    .push_valid(ev_valid), .push_data(ev_in), .pop(pop),
    .head_valid(head_valid), .head_data(head_data),
    .full(fifo_full), .drops(drops)
  );

  irw_ctrl_regs #(.IDX_W(IDX_W), .DROP_W(DROP_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .commit(commit), .commit_ovf(commit_ovf), .drops(drops),
    .ctrl(ctrl), .ring_base(ring_base), .copy_addr(copy_addr),
    .rptr_idx(rptr_idx), .wptr_idx(wptr_idx), .mask_idx(mask_idx),
    .ovf(ovf), .wptr_word(wptr_word), .irq(irq)
  );

  irw_vec_engine #(.IDX_W(IDX_W)) u_engine (
    .clk(clk), .rst_n(rst_core_n),
    .head_valid(head_valid), .head_data(head_data),
    .ring_en(ctrl.ring_en), .ovf_en(ctrl.ovf_en), .wb_en(ctrl.wb_en),
    .ring_base(ring_base), .copy_addr(copy_addr),
    .wptr_idx(wptr_idx), .rptr_idx(rptr_idx), .mask_idx(mask_idx),
    .wptr_word(wptr_word), .mem_ready(mem_wr_ready),
    .pop(pop), .mem_valid(mem_wr_valid), .mem_addr(mem_wr_addr), .mem_data(mem_wr_data),
    .commit(commit), .commit_ovf(commit_ovf)
  );
endmodule

// File: rtl/irw_checker.sv
module irw_checker
  import irw_pkg::*;
#(
  parameter int IDX_W  = 14,
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [39:0]       mem_addr,
  input logic [31:0]       mem_data,
  input logic              commit,
  input logic [IDX_W-1:0]  wptr_idx,
  input logic [IDX_W-1:0]  rptr_idx,
  input logic [IDX_W-1:0]  mask_idx,
  input logic              ovf,
  input irw_ctrl_t         ctrl,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic              ev_valid,
  input logic              fifo_full,
  input logic [DROP_W-1:0] drops
);
  // R11: a stalled beat keeps its address and data
  a_r11_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R8: interrupt only with both enables and pointers apart
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl.ring_en && ctrl.intr_en && (wptr_idx != rptr_idx)));

  // R3: each finished record moves the producer pointer one slot, modulo the ring
  a_r3_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !(reg_wr && reg_addr == RA_WPTR))
      |=> (wptr_idx == (IDX_W'($past(wptr_idx) + 1'b1) & $past(mask_idx))));

  // R7: clear control keeps the overflow flag low
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.ovf_clr |=> !ovf);

  // R6: without overflow mode a record never lands the producer on the consumer
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !ctrl.ovf_en) |-> ((IDX_W'(wptr_idx + 1'b1) & mask_idx) != rptr_idx));

  // R9: consumer write with rearm opens a one-cycle gap
  a_r9_rearm_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_RPTR && ctrl.rearm) |=> !irq);

  // R10: an event meeting a full queue is counted
  a_r10_drop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && fifo_full && (drops != '1)) |=> (drops == DROP_W'($past(drops) + 1'b1)));
endmodule

bind intr_ring_writer irw_checker #(.IDX_W(IDX_W), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .irq(irq),
  .mem_valid(mem_wr_valid), .mem_ready(mem_wr_ready),
  .mem_addr(mem_wr_addr), .mem_data(mem_wr_data),
  .commit(commit), .wptr_idx(wptr_idx), .rptr_idx(rptr_idx), .mask_idx(mask_idx),
  .ovf(ovf), .ctrl(ctrl), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .ev_valid(ev_valid), .fifo_full(fifo_full), .drops(drops)
);

// File: tb/intr_ring_writer_tb.sv
module intr_ring_writer_tb_top;
  import irw_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        ev_valid;
  logic [7:0]  ev_source, ev_ring, ev_vmid;
  logic [27:0] ev_payload;
  logic [15:0] ev_pasid;
  logic        mem_wr_valid, mem_wr_ready, irq;
  logic [39:0] mem_wr_addr;
  logic [31:0] mem_wr_data;

  intr_ring_writer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
    .ev_source(ev_source), .ev_payload(ev_payload), .ev_ring(ev_ring),
    .ev_vmid(ev_vmid), .ev_pasid(ev_pasid), .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit stall_mode = 1'b0;

  logic [39:0] exp_addr[$];
  logic [31:0] exp_data[$];
  string       exp_tag[$];

  // bench model of the ring state
  int          m_w, m_r, m_mask;
  bit          m_ovf, m_wben;
  logic [39:0] m_base, m_copy;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push_item(logic [39:0] a, logic [31:0] d, string t);
    exp_addr.push_back(a);
    exp_data.push_back(d);
    exp_tag.push_back(t);
  endtask

  function automatic logic [7:0]  k_src(int k);  return 8'h20 + 8'(k); endfunction
  function automatic logic [27:0] k_pay(int k);  return 28'hABC0000 + 28'(k); endfunction
  function automatic logic [7:0]  k_ring(int k); return 8'h01 + 8'(k); endfunction
  function automatic logic [7:0]  k_vm(int k);   return 8'h80 + 8'(k); endfunction
  function automatic logic [15:0] k_as(int k);   return 16'hF000 + 16'(k); endfunction

  // expected memory traffic for one record (R2, R3, R4, R5)
  task automatic push_vec(int k);
    logic [39:0] slot;
    bit full;
    slot = m_base + 40'(m_w * 16);
    full = (((m_w + 1) & m_mask) == m_r);
    push_item(slot + 40'd0,  {24'h0, k_src(k)}, "R2 word0");
    push_item(slot + 40'd4,  {4'h0, k_pay(k)}, "R2 word1");
    push_item(slot + 40'd8,  {k_as(k), k_vm(k), k_ring(k)}, "R2 word2");
    push_item(slot + 40'd12, 32'h0, "R2 word3");
    if (full) m_ovf = 1'b1;
    m_w = (m_w + 1) & m_mask;
    if (m_wben) push_item(m_copy, 32'(m_w * 16) | 32'(m_ovf), "R4 pointer copy");
  endtask

  task automatic send_ev(int k);
    @(negedge clk);
    ev_valid   = 1'b1;
    ev_source  = k_src(k);
    ev_payload = k_pay(k);
    ev_ring    = k_ring(k);
    ev_vmid    = k_vm(k);
    ev_pasid   = k_as(k);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_drain(string t);
    int n;
    n = 0;
    while (exp_addr.size() != 0 && n < 400) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    checks++;
    if (exp_addr.size() != 0) begin
      errors++;
      $display("FAIL %s actual %0d writes missing expected 0", t, exp_addr.size());
      exp_addr.delete();
      exp_data.delete();
      exp_tag.delete();
    end
  endtask

  // memory ready driver
  initial begin
    mem_wr_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      mem_wr_ready = stall_mode ? ~mem_wr_ready : 1'b1;
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_wr_valid && mem_wr_ready) begin
        checks++;
        if (exp_addr.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected write actual %h:%h expected none", mem_wr_addr, mem_wr_data);
        end else begin
          logic [39:0] ea;
          logic [31:0] ed;
          string       et;
          ea = exp_addr.pop_front();
          ed = exp_data.pop_front();
          et = exp_tag.pop_front();
          if (mem_wr_addr !== ea || mem_wr_data !== ed) begin
            errors++;
            $display("FAIL %s actual %h:%h expected %h:%h", et, mem_wr_addr, mem_wr_data, ea, ed);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    ev_valid = 1'b0; ev_source = '0; ev_payload = '0; ev_ring = '0; ev_vmid = '0; ev_pasid = '0;
    m_w = 0; m_r = 0; m_mask = 3; m_ovf = 1'b0; m_wben = 1'b1;
    m_base = 40'h0012345600; m_copy = 40'h5A0000ABC0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq", 64'(irq), 64'd0);
    check("R1 mem_wr_valid", 64'(mem_wr_valid), 64'd0);
    reg_read(RA_WPTR, rd);  check("R1 producer pointer", 64'(rd), 64'd0);
    reg_read(RA_DROPS, rd); check("R1 discard count", 64'(rd), 64'd0);

    reg_write(RA_BASE, 32'h00123456);
    reg_write(RA_WBLO, 32'h0000ABC0);
    reg_write(RA_WBHI, 32'h0000005A);
    reg_write(RA_CTRL, 32'h0000_0417);  // size 4, copy, overflow mode, irq, ring

    // R2 R4 first record
    push_vec(0); send_ev(0); wait_drain("R2 first record");
    reg_read(RA_WPTR, rd); check("R3 pointer after one record", 64'(rd), 64'h10);
    check("R8 irq with unread record", 64'(irq), 64'd1);

    // R11 R4 stalled record without pointer copy
    reg_write(RA_CTRL, 32'h0000_0407); m_wben = 1'b0;
    stall_mode = 1'b1;
    push_vec(1); send_ev(1); wait_drain("R11 stalled record");
    stall_mode = 1'b0;
    reg_read(RA_WPTR, rd); check("R3 pointer after two records", 64'(rd), 64'h20);

    // R8 interrupt enable gating
    reg_write(RA_CTRL, 32'h0000_0415); m_wben = 1'b1;
    check("R8 irq with interrupt enable clear", 64'(irq), 64'd0);
    reg_write(RA_CTRL, 32'h0000_0417);
    check("R8 irq restored", 64'(irq), 64'd1);
    reg_write(RA_RPTR, 32'h20); m_r = 2;
    check("R8 irq when pointers equal", 64'(irq), 64'd0);

    // R3 wrap across the ring end
    for (int k = 2; k < 5; k++) begin
      push_vec(k); send_ev(k); wait_drain("R3 wrap record");
    end
    reg_read(RA_WPTR, rd); check("R3 pointer wrapped", 64'(rd), 64'h10);

    // R5 overflow with overwrite
    push_vec(5); send_ev(5); wait_drain("R5 overflow record");
    reg_read(RA_WPTR, rd); check("R5 overflow flag set", 64'(rd), 64'h21);

    // R7 clear control
    reg_write(RA_CTRL, 32'h0000_041F);
    reg_write(RA_CTRL, 32'h0000_0417); m_ovf = 1'b0;
    reg_read(RA_WPTR, rd); check("R7 flag cleared", 64'(rd), 64'h20);

    // R6 hold-back when overflow mode is off
    reg_write(RA_CTRL, 32'h0000_0413);
    for (int k = 6; k < 9; k++) begin
      push_vec(k); send_ev(k); wait_drain("R6 filling record");
    end
    send_ev(9);
    repeat (20) @(negedge clk);
    reg_read(RA_WPTR, rd); check("R6 full ring holds record", 64'(rd), 64'h10);
    m_r = 3; push_vec(9);
    reg_write(RA_RPTR, 32'h30);
    wait_drain("R6 released record");
    reg_read(RA_WPTR, rd); check("R6 pointer after release", 64'(rd), 64'h20);

    // R10 queue and discard with the ring disabled
    reg_write(RA_CTRL, 32'h0000_0412);
    check("R8 irq with ring disabled", 64'(irq), 64'd0);
    @(negedge clk);
    for (int k = 10; k < 15; k++) begin
      ev_valid = 1'b1; ev_source = k_src(k); ev_payload = k_pay(k);
      ev_ring = k_ring(k); ev_vmid = k_vm(k); ev_pasid = k_as(k);
      @(negedge clk);
    end
    ev_valid = 1'b0;
    repeat (5) @(negedge clk);
    reg_read(RA_DROPS, rd); check("R10 discard count", 64'(rd), 64'd1);
    reg_read(RA_WPTR, rd);  check("R10 no write while disabled", 64'(rd), 64'h20);
    reg_write(RA_RPTR, 32'h0); reg_write(RA_WPTR, 32'h0);
    m_r = 0; m_w = 0;
    for (int k = 10; k < 14; k++) push_vec(k);
    reg_write(RA_CTRL, 32'h0000_0417);
    wait_drain("R10 queued records in order");
    reg_read(RA_WPTR, rd); check("R5 overflow on queued run", 64'(rd), 64'h01);

    // R9 rearm gap
    reg_write(RA_CTRL, 32'h0000_0437);
    reg_write(RA_RPTR, 32'h10);
    check("R9 gap cycle", 64'(irq), 64'd0);
    @(negedge clk);
    check("R9 irq raised again", 64'(irq), 64'd1);
    reg_write(RA_CTRL, 32'h0000_0417);
    reg_write(RA_RPTR, 32'h20);
    check("R9 no gap without rearm", 64'(irq), 64'd1);

    // R12 pointer register writes
    reg_write(RA_WPTR, 32'h30);
    reg_read(RA_WPTR, rd); check("R12 producer write clears flag", 64'(rd), 64'h30);
    reg_write(RA_RPTR, 32'h2F);
    reg_read(RA_RPTR, rd); check("R12 low bits ignored", 64'(rd), 64'h20);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule